// File: doc/BRIEF.md
# Parallel camera capture front end

This block sits directly behind the pins of a parallel image sensor. It samples the horizontal and vertical sync pins and a data bus of up to 16 bits, and it emits a stream of raw data words in the pixel clock domain. Each word carries flags that mark the start of a frame and the start of a line. Static configuration sets several things: whether capture is on, which pixel-clock edge samples the pins, the blanking level of each sync pin, the sync mode and the bus width.

Two sync modes exist. In pin mode the sync pins frame the data. In embedded mode the sync pins are ignored and framing comes from four-byte codes carried on the low eight data bits. A pixel formatter or a clock-domain crossing FIFO consumes the output. The output has no ready input, because a sensor cannot be stalled. The consumer must accept every cycle in which `out_valid` is high, and no word is ever held back or repeated.

Top module: `cam_capture_top`

## Requirements
- R1: During reset, and afterwards until capture is enabled, `out_valid`, `out_sof`, `out_sol` and `out_data` are all zero.
- R2: With `cfg_edge_rise`=1 the pins are captured on the rising clock edge. With `cfg_edge_rise`=0 they are captured on the falling edge.
- R3: In pin mode a word is emitted for a capture only if `pin_hsync` differs from `cfg_hs_blank_lvl` and `pin_vsync` differs from `cfg_vs_blank_lvl`. Each polarity bit is the level of its pin during blanking. Words leave in capture order.
- R4: `out_sof` is set on the first word after the frame begins, and every word with `out_sof` also carries `out_sol`. In pin mode the frame begins when vsync leaves its blanking level. In embedded mode it begins with a frame-start code.
- R5: `out_sol` is set on the first word of each line and on no other word.
- R6: If capture is enabled in the middle of a frame, no word is emitted until the next frame boundary. In pin mode that boundary is vsync at its blanking level. In embedded mode it is a frame-start code.
- R7: `cfg_width` codes 0 to 4 capture 8, 10, 12, 14 or 16 bits, and the unused upper bits of `out_data` are zero. Codes 5 to 7 are reserved and emit no words.
- R8: In embedded mode a sync code is the byte sequence 0xFF, 0x00, 0x00 followed by a status byte. In the status byte, bit 5 = 1 means frame (0 means line) and bit 4 = 1 means end (0 means start). All other status bits are ignored. Code bytes are never emitted as data, and the sync pins have no effect.
- R9: In embedded mode, data bytes are emitted only between a start code and the next end code, and they appear in bits [7:0] of `out_data`. A frame-start code also opens the first line.
- R10: Embedded mode emits words only when `cfg_width` is 0 (8 bits). With any other width it emits nothing.
- R11: While `cfg_enable` is low, `out_valid` is low from the next clock on and all framing state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Capture on |
| cfg_edge_rise | input | 1 | 1: capture on rising edge, 0: falling edge |
| cfg_hs_blank_lvl | input | 1 | Level of hsync while data is not valid |
| cfg_vs_blank_lvl | input | 1 | Level of vsync while data is not valid |
| cfg_embedded | input | 1 | 1: framing from embedded codes |
| cfg_width | input | 3 | Bus width code |
| pin_hsync | input | 1 | Horizontal sync pin |
| pin_vsync | input | 1 | Vertical sync pin |
| pin_data | input | DW | Sensor data bus |
| out_valid | output | 1 | Word valid, no back-pressure |
| out_sof | output | 1 | First word of a frame |
| out_sol | output | 1 | First word of a line |
| out_data | output | DW | Captured word, upper bits zero |

## Verification
The assertions check every cycle that nothing leaves while capture is off. They also check that flags appear only on valid words and that a frame flag always comes with a line flag. Unused upper bits must be zero, and reserved widths and embedded mode at a width other than 8 bits must stay silent. A pin-mode word must come from a capture in which both sync pins were away from their blanking levels. Other behaviour shows only in the bench's scenarios against a reference model. That covers which edge was sampled, the exact word sequence and where the flags fall, the wait for a frame boundary after a mid-frame enable, and the removal of code bytes from the embedded stream.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
  // largest legal width code (16-bit bus)
  localparam int unsigned MAX_WCODE = 4;
  // embedded code: one lead byte, zero bytes, one status byte
  localparam logic [7:0]  CODE_LEAD = 8'hFF;
  localparam logic [7:0]  CODE_ZERO = 8'h00;
  localparam int unsigned CODE_LEN  = 4;
  localparam int unsigned FRAME_BIT = 5;
  localparam int unsigned END_BIT   = 4;

  typedef enum logic [1:0] {
    EV_LINE_START  = 2'b00,
    EV_LINE_END    = 2'b01,
    EV_FRAME_START = 2'b10,
    EV_FRAME_END   = 2'b11
  } code_event_e;
endpackage

// File: rtl/cam_edge_sampler.sv
module cam_edge_sampler #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_rise,
  input  logic          hs_pin,
  input  logic          vs_pin,
  input  logic [DW-1:0] d_pin,
  output logic          hs_s,
  output logic          vs_s,
  output logic [DW-1:0] d_s
);
  localparam int BW = DW + 2;

  logic [BW-1:0] bus_in, rise_q, fall_q, fall_r, pick;

  assign bus_in = {hs_pin, vs_pin, d_pin};

  // rising-edge capture, one register to the posedge domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= bus_in;
  end

  // falling-edge capture, then retimed to the following posedge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fall_r <= '0;
    else        fall_r <= fall_q;
  end

  // both paths deliver a capture after the same posedge
  assign pick = edge_rise ? rise_q : fall_r;
  assign {hs_s, vs_s, d_s} = pick;
endmodule

// File: rtl/cam_pin_framer.sv
module cam_pin_framer (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hs_s,
  input  logic vs_s,
  input  logic hs_blank_lvl,
  input  logic vs_blank_lvl,
  output logic word_v,
  output logic sof,
  output logic sol
);
  logic armed, pend_f, pend_l;
  logic v_blank, h_blank;

  assign v_blank = (vs_s == vs_blank_lvl);
  assign h_blank = (hs_s == hs_blank_lvl);

  assign word_v = run && armed && !v_blank && !h_blank;
  assign sof    = word_v && pend_f;
  assign sol    = word_v && pend_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      pend_f <= 1'b0;
      pend_l <= 1'b0;
    end else if (!run) begin
      armed  <= 1'b0;
      pend_f <= 1'b0;
      pend_l <= 1'b0;
    end else begin
      // a vertical blank seen after enable marks a frame boundary
      armed <= armed | v_blank;
      if (v_blank)     pend_f <= 1'b1;
      else if (word_v) pend_f <= 1'b0;
      if (v_blank || h_blank) pend_l <= 1'b1;
      else if (word_v)        pend_l <= 1'b0;
    end
  end
endmodule

// File: rtl/cam_code_framer.sv
module cam_code_framer
  import cam_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [7:0] byte_in,
  output logic       word_v,
  output logic       sof,
  output logic       sol,
  output logic [7:0] byte_out
);
  localparam int LOOK = CODE_LEN - 1;
  localparam int SKW  = $clog2(LOOK + 1);

  // pipe[0] newest byte, pipe[LOOK] the byte being decided
  logic [7:0]     pipe [LOOK+1];
  logic [SKW-1:0] skip;
  logic           armed, in_line, pend_f, pend_l;
  logic           zeros_ok, is_code;
  code_event_e    ev;

  always_comb begin
    zeros_ok = 1'b1;
    for (int k = 1; k < LOOK; k++)
      if (pipe[k] != CODE_ZERO) zeros_ok = 1'b0;
  end

  assign is_code  = (skip == '0) && (pipe[LOOK] == CODE_LEAD) && zeros_ok;
  assign ev       = code_event_e'({pipe[0][FRAME_BIT], pipe[0][END_BIT]});
  assign word_v   = run && (skip == '0) && !is_code && in_line;
  assign sof      = word_v && pend_f;
  assign sol      = word_v && pend_l;
  assign byte_out = pipe[LOOK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= LOOK; k++) pipe[k] <= '0;
    end else if (!run) begin
      for (int k = 0; k <= LOOK; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= byte_in;
      for (int k = 1; k <= LOOK; k++) pipe[k] <= pipe[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip <= '0; armed <= 1'b0; in_line <= 1'b0;
      pend_f <= 1'b0; pend_l <= 1'b0;
    end else if (!run) begin
      skip <= '0; armed <= 1'b0; in_line <= 1'b0;
      pend_f <= 1'b0; pend_l <= 1'b0;
    end else if (is_code) begin
      skip <= SKW'(LOOK);
      unique case (ev)
        EV_FRAME_START: begin
          armed <= 1'b1; in_line <= 1'b1;
          pend_f <= 1'b1; pend_l <= 1'b1;
        end
        EV_LINE_START: begin
          if (armed) begin
            in_line <= 1'b1;
            pend_l  <= 1'b1;
          end
        end
        EV_LINE_END, EV_FRAME_END: in_line <= 1'b0;
        default: ;
      endcase
    end else begin
      if (skip != '0) skip <= skip - 1'b1;
      if (word_v) begin
        pend_f <= 1'b0;
        pend_l <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cam_capture_top.sv
module cam_capture_top
  import cam_cap_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_edge_rise,
  input  logic          cfg_hs_blank_lvl,
  input  logic          cfg_vs_blank_lvl,
  input  logic          cfg_embedded,
  input  logic [2:0]    cfg_width,
  input  logic          pin_hsync,
  input  logic          pin_vsync,
  input  logic [DW-1:0] pin_data,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_sol,
  output logic [DW-1:0] out_data
);
  logic          hs_s, vs_s;
  logic [DW-1:0] d_s, keep;
  logic          en_q, width_ok, pin_run, code_run;
  logic          p_v, p_sof, p_sol;
  logic          c_v, c_sof, c_sol;
  logic [7:0]    c_byte;
  logic          sel_v, sel_sof, sel_sol;
  logic [DW-1:0] sel_data;

  cam_edge_sampler #(.DW(DW)) u_smp (
    .clk(clk), .rst_n(rst_n), .edge_rise(cfg_edge_rise),
    .hs_pin(pin_hsync), .vs_pin(pin_vsync), .d_pin(pin_data),
    .hs_s(hs_s), .vs_s(vs_s), .d_s(d_s)
  );

  // enable delayed to line up with the sampler output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= cfg_enable;
  end

  assign width_ok = (cfg_width <= 3'(MAX_WCODE));
  assign pin_run  = en_q && !cfg_embedded && width_ok;
  assign code_run = en_q && cfg_embedded && (cfg_width == 3'd0);

  always_comb begin
    for (int b = 0; b < DW; b++)
      keep[b] = (b < 8 + 2 * int'(cfg_width));
  end

  cam_pin_framer u_pin (
    .clk(clk), .rst_n(rst_n), .run(pin_run),
    .hs_s(hs_s), .vs_s(vs_s),
    .hs_blank_lvl(cfg_hs_blank_lvl), .vs_blank_lvl(cfg_vs_blank_lvl),
    .word_v(p_v), .sof(p_sof), .sol(p_sol)
  );

  cam_code_framer u_code (
    .clk(clk), .rst_n(rst_n), .run(code_run), .byte_in(d_s[7:0]),
    .word_v(c_v), .sof(c_sof), .sol(c_sol), .byte_out(c_byte)
  );

  always_comb begin
    if (cfg_embedded) begin
      sel_v    = c_v;
      sel_sof  = c_sof;
      sel_sol  = c_sol;
      sel_data = DW'(c_byte);
    end else begin
      sel_v    = p_v;
      sel_sof  = p_sof;
      sel_sol  = p_sol;
      sel_data = d_s & keep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_sof <= 1'b0; out_sol <= 1'b0; out_data <= '0;
    end else if (cfg_enable && sel_v) begin
      out_valid <= 1'b1; out_sof <= sel_sof; out_sol <= sel_sol; out_data <= sel_data;
    end else begin
      out_valid <= 1'b0; out_sof <= 1'b0; out_sol <= 1'b0; out_data <= '0;
    end
  end
endmodule

// File: rtl/cam_capture_checker.sv
module cam_capture_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_enable,
  input logic          cfg_embedded,
  input logic [2:0]    cfg_width,
  input logic          cfg_hs_blank_lvl,
  input logic          cfg_vs_blank_lvl,
  input logic          hs_s,
  input logic          vs_s,
  input logic          out_valid,
  input logic          out_sof,
  input logic          out_sol,
  input logic [DW-1:0] out_data
);
  function automatic logic [DW-1:0] allowed_bits(input logic [2:0] code);
    logic [DW-1:0] m;
    for (int b = 0; b < DW; b++) m[b] = (b < 8 + 2 * int'(code));
    return m;
  endfunction

  assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !out_valid);

  assert_frame_has_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_sol && out_valid));

  assert_line_on_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> out_valid);

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & ~allowed_bits(cfg_width)) == '0));

  assert_reserved_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_width > 3'd4) && $past(cfg_width > 3'd4)) |-> !out_valid);

  assert_pin_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_embedded && $past(!cfg_embedded))
      |-> $past((hs_s != cfg_hs_blank_lvl) && (vs_s != cfg_vs_blank_lvl)));

  assert_code_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_embedded) |-> (cfg_width == 3'd0));

  assert_code_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_embedded) |-> ((out_data >> 8) == '0));
endmodule

bind cam_capture_top cam_capture_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_embedded(cfg_embedded),
  .cfg_width(cfg_width), .cfg_hs_blank_lvl(cfg_hs_blank_lvl),
  .cfg_vs_blank_lvl(cfg_vs_blank_lvl), .hs_s(hs_s), .vs_s(vs_s),
  .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol), .out_data(out_data)
);

// File: tb/sim_cam_capture_top.sv
module sim_cam_capture_top;
  localparam int DW   = 16;
  localparam int MAXN = 1024;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_enable, cfg_edge_rise, cfg_hs_blank_lvl, cfg_vs_blank_lvl, cfg_embedded;
  logic [2:0] cfg_width;
  logic pin_hsync, pin_vsync;
  logic [DW-1:0] pin_data;
  logic out_valid, out_sof, out_sol;
  logic [DW-1:0] out_data;

  cam_capture_top #(.DW(DW)) u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic          st_hs [MAXN];
  logic          st_vs [MAXN];
  logic [DW-1:0] st_cap [MAXN];
  logic [DW-1:0] st_oth [MAXN];
  int n;
  logic [DW-1:0] ex_d [MAXN];
  logic          ex_f [MAXN];
  logic          ex_l [MAXN];
  int ne;
  logic [DW-1:0] got_d [MAXN];
  logic          got_f [MAXN];
  logic          got_l [MAXN];
  int ng;
  bit mon_on = 0;

  always @(posedge clk) begin
    #2;
    if (mon_on && out_valid) begin
      if (ng < MAXN) begin
        got_d[ng] = out_data; got_f[ng] = out_sof; got_l[ng] = out_sol;
      end
      ng++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] keep_bits(input int code);
    logic [DW-1:0] m;
    for (int b = 0; b < DW; b++) m[b] = (b < 8 + 2 * code);
    return m;
  endfunction

  task automatic push(input logic hs, input logic vs, input logic [DW-1:0] cap);
    st_hs[n] = hs; st_vs[n] = vs; st_cap[n] = cap; st_oth[n] = DW'($urandom);
    n++;
  endtask

  // pin-mode stimulus: optional partial frame, then whole frames
  task automatic gen_pin(input int frames, input bit mid);
    logic hp, vp;
    hp = cfg_hs_blank_lvl; vp = cfg_vs_blank_lvl; n = 0;
    if (mid)
      for (int l = 0; l < 2; l++) begin
        repeat (2) push(hp, !vp, DW'($urandom));
        repeat (4) push(!hp, !vp, DW'($urandom));
      end
    for (int f = 0; f < frames; f++) begin
      repeat (3 + $urandom % 3) push(1'($urandom), vp, DW'($urandom));
      for (int l = 0; l < 2 + int'($urandom % 3); l++) begin
        repeat (2 + $urandom % 2) push(hp, !vp, DW'($urandom));
        repeat (2 + $urandom % 7) push(!hp, !vp, DW'($urandom));
      end
    end
    repeat (4) push(hp, vp, DW'($urandom));
  endtask

  task automatic pushb(input logic [7:0] b);
    push(1'($urandom), 1'($urandom), {8'($urandom), b});
  endtask

  task automatic code(input bit fr, input bit en);
    pushb(8'hFF); pushb(8'h00); pushb(8'h00);
    pushb({1'b1, 1'($urandom), fr, en, 4'($urandom)});
  endtask

  task automatic data_bytes(input int k);
    repeat (k) pushb(8'(1 + $urandom % 254));
  endtask

  task automatic gen_emb(input int frames, input bit mid);
    n = 0;
    if (mid) begin
      code(0, 0); data_bytes(3); code(0, 1); repeat (2) pushb(8'h10);
    end
    for (int f = 0; f < frames; f++) begin
      repeat (3) pushb(8'h10);
      code(1, 0); data_bytes(2 + $urandom % 6); code(0, 1); repeat (2) pushb(8'h10);
      for (int l = 0; l < 1 + int'($urandom % 2); l++) begin
        code(0, 0); data_bytes(1 + $urandom % 6); code(0, 1); repeat (2) pushb(8'h10);
      end
      code(1, 1);
    end
    repeat (8) pushb(8'h10);
  endtask

  // reference model, written from the requirements
  task automatic model(input bit en_on);
    bit armed, pf, pl, inl;
    int w;
    ne = 0; armed = 0; pf = 0; pl = 0; inl = 0;
    w = int'(cfg_width);
    if (!en_on || w > 4) return;
    if (!cfg_embedded) begin
      for (int j = 0; j < n; j++) begin
        bit vb, hb;
        vb = (st_vs[j] == cfg_vs_blank_lvl);
        hb = (st_hs[j] == cfg_hs_blank_lvl);
        if (armed && !vb && !hb) begin
          ex_d[ne] = st_cap[j] & keep_bits(w); ex_f[ne] = pf; ex_l[ne] = pl; ne++;
          pf = 0; pl = 0;
        end
        if (vb) begin armed = 1; pf = 1; end
        if (vb || hb) pl = 1;
      end
    end else if (w == 0) begin
      int j;
      j = 0;
      while (j < n) begin
        if (j + 3 < n && st_cap[j][7:0] == 8'hFF && st_cap[j+1][7:0] == 8'h00
            && st_cap[j+2][7:0] == 8'h00) begin
          logic [7:0] s;
          s = st_cap[j+3][7:0];
          if (s[5] && !s[4]) begin armed = 1; inl = 1; pf = 1; pl = 1; end
          else if (!s[5] && !s[4]) begin if (armed) begin inl = 1; pl = 1; end end
          else inl = 0;
          j += 4;
        end else begin
          if (inl) begin
            ex_d[ne] = DW'(st_cap[j][7:0]); ex_f[ne] = pf; ex_l[ne] = pl; ne++;
            pf = 0; pl = 0;
          end
          j++;
        end
      end
    end
  endtask

  task automatic run_scn(input bit en_on, input string t_cnt, input string t_dat);
    model(en_on);
    ng = 0; mon_on = 1;
    for (int j = 0; j < n; j++) begin
      @(posedge clk); #1;
      if (j == 0) cfg_enable = en_on;
      pin_hsync = st_hs[j]; pin_vsync = st_vs[j];
      pin_data = cfg_edge_rise ? st_oth[j] : st_cap[j];
      #4;
      pin_data = cfg_edge_rise ? st_cap[j] : st_oth[j];
    end
    for (int j = 0; j < 12; j++) begin
      @(posedge clk); #1;
      pin_hsync = cfg_hs_blank_lvl; pin_vsync = cfg_vs_blank_lvl; pin_data = 16'h0010;
    end
    @(posedge clk); #1; cfg_enable = 0;
    repeat (3) @(posedge clk);
    #3; mon_on = 0;
    check(ng == ne, t_cnt, "word count", ng, ne);
    for (int k = 0; k < ne && k < ng; k++) begin
      check(got_d[k] == ex_d[k], t_dat, $sformatf("data word %0d", k), int'(got_d[k]), int'(ex_d[k]));
      check(got_f[k] == ex_f[k], "R4", $sformatf("frame flag word %0d", k), int'(got_f[k]), int'(ex_f[k]));
      check(got_l[k] == ex_l[k], "R5", $sformatf("line flag word %0d", k), int'(got_l[k]), int'(ex_l[k]));
    end
  endtask

  task automatic set_cfg(input bit edge_r, input bit hp, input bit vp, input bit emb, input int w);
    @(posedge clk); #1;
    cfg_edge_rise = edge_r; cfg_hs_blank_lvl = hp; cfg_vs_blank_lvl = vp;
    cfg_embedded = emb; cfg_width = 3'(w);
    pin_hsync = hp; pin_vsync = vp;
    repeat (2) @(posedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; cfg_enable = 0; cfg_edge_rise = 1; cfg_hs_blank_lvl = 0;
    cfg_vs_blank_lvl = 0; cfg_embedded = 0; cfg_width = 0;
    pin_hsync = 0; pin_vsync = 0; pin_data = 0;
    repeat (3) @(posedge clk);
    #2;
    check(!out_valid && !out_sof && !out_sol && out_data == '0, "R1", "outputs in reset",
          int'({out_valid, out_sof, out_sol}), 0);
    #1; rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    check(!out_valid && out_data == '0, "R1", "outputs after reset, disabled",
          int'(out_valid), 0);

    // R3 R2 R7: random pin-mode configurations
    for (int s = 0; s < 8; s++) begin
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 0, s % 5);
      gen_pin(2, 0);
      run_scn(1, "R3", "R2 R7");
    end
    // R2: both edges, directed
    set_cfg(0, 0, 0, 0, 4); gen_pin(1, 0); run_scn(1, "R2", "R2");
    set_cfg(1, 1, 1, 0, 4); gen_pin(1, 0); run_scn(1, "R2", "R2");
    // R6: enable in the middle of a frame, pin mode
    set_cfg(1, 1, 0, 0, 0); gen_pin(1, 1); run_scn(1, "R6", "R6");
    // R7: reserved width codes stay silent
    set_cfg(1, 0, 1, 0, 6); gen_pin(1, 0); run_scn(1, "R7", "R7");
    set_cfg(0, 0, 1, 0, 5); gen_pin(1, 0); run_scn(1, "R7", "R7");
    // R8 R9: embedded codes, both edges
    set_cfg(1, 0, 0, 1, 0); gen_emb(2, 0); run_scn(1, "R8", "R9");
    set_cfg(0, 1, 1, 1, 0); gen_emb(2, 0); run_scn(1, "R8", "R9");
    // R6: embedded mid-frame enable
    set_cfg(1, 0, 1, 1, 0); gen_emb(1, 1); run_scn(1, "R6", "R9");
    // R10: embedded at a wider bus is silent
    set_cfg(1, 0, 0, 1, 2); gen_emb(1, 0); run_scn(1, "R10", "R10");
    // R11: capture held off
    set_cfg(1, 0, 0, 0, 0); gen_pin(1, 0); run_scn(0, "R11", "R11");
    set_cfg(1, 0, 0, 1, 0); gen_emb(1, 0); run_scn(0, "R11", "R11");

    done = 1;
    summary();
    $finish;
  end
endmodule